// File: doc/BRIEF.md
# Edge-Distance Serial Decoder

This block recovers a bit stream from one receive wire that carries no clock. Each bit is encoded by how long the line stays at one level before it toggles again, and either polarity of toggle closes an interval. A short spacing stands for '0' and a spacing of about twice that length stands for '1'. A periodic step tick sets the sampling grid. The decoder measures every spacing in whole steps and sorts it into one of three windows: short, long, or too long.

The line rests low between telegrams. A telegram opens with a high pulse long enough to decode as '1', and the decoder marks that first bit with a start flag. A spacing that runs past the long window is not data. It raises a single timeout strobe, which closes the telegram and lets the next one be recognised. Framing above the bit level and any checksum belong to the logic that consumes the decoded bits.

Top module: `edge_gap_decoder`

## Requirements
- R1: While reset is held, and on the first cycle after it, `bit_valid`, `bit_out`, `start_flag` and `timeout_flag` are all 0.
- R2: When a line toggle closes an interval of 1 to 7 steps, `bit_valid` pulses with `bit_out` = 0.
- R3: When a line toggle closes an interval of 8 to 14 steps, `bit_valid` pulses with `bit_out` = 1.
- R4: When 15 steps pass with no toggle, `timeout_flag` pulses exactly once in the 15th step and no bit is produced. The flag does not pulse again until the line toggles.
- R5: A toggle that lands in the 15th step counts as a timeout and produces no bit. The next interval is measured from that toggle.
- R6: Rising and falling toggles both close intervals, and the decoded value does not depend on polarity.
- R7: `start_flag` pulses together with `bit_valid` when three things hold: the decoded bit is the first one since reset or since the last timeout, its value is '1', and a falling toggle closed it (a high pulse). Otherwise `start_flag` stays 0.
- R8: After reset, or after a timeout step that had no toggle, the first toggle opens an interval and produces no bit.
- R9: The line is examined only at step ticks. A brief excursion that returns to the previous level before the next tick has no effect.
- R10: `bit_valid` and `timeout_flag` are one-cycle strobes. Each appears in the clock cycle that follows a cycle with `step_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_tick | input | 1 | One-cycle pulse per sampling step |
| line_in | input | 1 | Asynchronous receive line |
| bit_out | output | 1 | Decoded bit value, meaningful with bit_valid |
| bit_valid | output | 1 | One-cycle strobe for a decoded bit |
| start_flag | output | 1 | First decoded bit of a telegram |
| timeout_flag | output | 1 | One-cycle strobe for an over-long interval |

## Verification
The hardest case to reach is a toggle that falls in exactly the step where the interval reaches the timeout length. One step earlier it would decode as '1', and one step later the counter would already be saturated and idle. The directed part of the stimulus holds the line for exactly fifteen steps and then follows with a short interval, to show that counting restarted at that toggle. The random part draws interval lengths from 1 to 17 steps, so the window edges, the timeout step and the saturated idle state all occur many times. It also injects sub-step glitches between ticks.

// File: rtl/edge_gap_pkg.sv
// Package edge_gap_pkg
// Shared interval classes and the window classification used by the decoder.
// Assumes interval lengths are counted in whole sampling steps, at least 1.
package edge_gap_pkg;

    typedef enum logic [1:0] {
        GAP_NONE = 2'd0,
        GAP_ZERO = 2'd1,
        GAP_ONE  = 2'd2,
        GAP_TMO  = 2'd3
    } gap_kind_t;

    // Sort an interval length into the short, long or timeout window.
    function automatic gap_kind_t classify_gap(input int unsigned gap,
                                               input int unsigned zero_max,
                                               input int unsigned one_max);
        if (gap == 0)                 return GAP_NONE;
        else if (gap <= zero_max)     return GAP_ZERO;
        else if (gap <= one_max)      return GAP_ONE;
        else if (gap == one_max + 1)  return GAP_TMO;
        else                          return GAP_NONE;
    endfunction

endpackage

// File: rtl/line_sync.sv
// Module line_sync
// Two-flop synchronizer that brings the asynchronous receive line into clk.
// Assumes the line rests low, so the flops reset to 0.
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gap_counter.sv
// Module gap_counter
// Samples the synchronized line on each step tick, finds toggles and counts
// the steps since the last one. The count saturates one past the long window,
// and it starts saturated so that the first toggle only opens an interval.
// Assumes step_tick is a one-cycle pulse.
module gap_counter #(
    parameter int CNT_W   = 4,
    parameter int CNT_SAT = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_tick,
    input  logic         line_s,
    output logic         edge_evt,
    output logic         edge_lvl,
    output logic [CNT_W:0] gap_len
);
    logic             smp_q;
    logic [CNT_W-1:0] cnt_q;

    assign edge_evt = step_tick && (line_s != smp_q);
    assign edge_lvl = line_s;
    assign gap_len  = {1'b0, cnt_q} + 1'b1;

    // Hold the level seen at the last tick and the steps since the last toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
            cnt_q <= CNT_W'(CNT_SAT);
        end else if (step_tick) begin
            smp_q <= line_s;
            if (edge_evt)                      cnt_q <= '0;
            else if (cnt_q != CNT_W'(CNT_SAT)) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Between ticks nothing is sampled or counted.
    assert_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !step_tick |=> ($stable(cnt_q) && $stable(smp_q)));

    // A toggle restarts the interval count.
    assert_restart_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_evt |=> (cnt_q == '0));
endmodule

// File: rtl/gap_classifier.sv
// Module gap_classifier
// Turns closed intervals into registered bit, start and timeout strobes, and
// tracks whether a telegram is open. Assumes gap_len counts the current step.
module gap_classifier
    import edge_gap_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int ZERO_MAX = 7,
    parameter int ONE_MAX  = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step_tick,
    input  logic           edge_evt,
    input  logic           edge_lvl,
    input  logic [CNT_W:0] gap_len,
    output logic           bit_out,
    output logic           bit_valid,
    output logic           start_flag,
    output logic           timeout_flag
);
    gap_kind_t kind;
    logic      bit_now;
    logic      tmo_now;
    logic      idle_q;

    // Classify the interval that would close in this step.
    always_comb begin
        kind    = classify_gap(int'(gap_len), ZERO_MAX, ONE_MAX);
        bit_now = edge_evt && (kind == GAP_ZERO || kind == GAP_ONE);
        tmo_now = step_tick && (kind == GAP_TMO);
    end

    // Register the strobes and the between-telegrams state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out      <= 1'b0;
            bit_valid    <= 1'b0;
            start_flag   <= 1'b0;
            timeout_flag <= 1'b0;
            idle_q       <= 1'b1;
        end else begin
            bit_valid    <= bit_now;
            timeout_flag <= tmo_now;
            start_flag   <= bit_now && idle_q && (kind == GAP_ONE) && !edge_lvl;
            if (bit_now) bit_out <= (kind == GAP_ONE);
            if (tmo_now)      idle_q <= 1'b1;
            else if (bit_now) idle_q <= 1'b0;
        end
    end

    // A step is either data or a timeout, never both.
    assert_bit_or_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_valid && timeout_flag));

    // A start mark always rides on a decoded '1'.
    assert_start_is_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_flag |-> (bit_valid && bit_out));

    // Two timeouts never come back to back.
    assert_timeout_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_flag |=> !timeout_flag);
endmodule

// File: rtl/edge_gap_decoder.sv
// Module edge_gap_decoder
// Top of the edge-distance decoder: synchronizer, step counter, classifier.
// Assumes step_tick pulses for one clk cycle per step and is at least
// three clk cycles apart, so a line change settles through the synchronizer.
module edge_gap_decoder #(
    parameter int ZERO_MAX = 7,
    parameter int ONE_MAX  = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_tick,
    input  logic line_in,
    output logic bit_out,
    output logic bit_valid,
    output logic start_flag,
    output logic timeout_flag
);
    localparam int CNT_SAT = ONE_MAX + 1;
    localparam int CNT_W   = $clog2(CNT_SAT + 1);

    logic           line_s;
    logic           edge_evt;
    logic           edge_lvl;
    logic [CNT_W:0] gap_len;

    line_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (line_in),
        .q_sync  (line_s)
    );

    gap_counter #(.CNT_W(CNT_W), .CNT_SAT(CNT_SAT)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_tick (step_tick),
        .line_s    (line_s),
        .edge_evt  (edge_evt),
        .edge_lvl  (edge_lvl),
        .gap_len   (gap_len)
    );

    gap_classifier #(.CNT_W(CNT_W), .ZERO_MAX(ZERO_MAX), .ONE_MAX(ONE_MAX)) u_cls (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_tick    (step_tick),
        .edge_evt     (edge_evt),
        .edge_lvl     (edge_lvl),
        .gap_len      (gap_len),
        .bit_out      (bit_out),
        .bit_valid    (bit_valid),
        .start_flag   (start_flag),
        .timeout_flag (timeout_flag)
    );

    // Strobes only follow a step tick.
    assert_strobe_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid || timeout_flag) |-> $past(step_tick));
endmodule

// File: tb/sim_edge_gap_decoder.sv
module sim_edge_gap_decoder;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_tick = 1'b0;
    logic line_in = 1'b0;
    logic bit_out, bit_valid, start_flag, timeout_flag;

    int checks = 0;
    int errors = 0;

    // Reference state built from the requirements.
    logic m_lvl = 1'b0;
    int   m_cnt = 15;
    logic m_idle = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_gap_decoder u0 (
        .clk(clk), .rst_n(rst_n), .step_tick(step_tick), .line_in(line_in),
        .bit_out(bit_out), .bit_valid(bit_valid),
        .start_flag(start_flag), .timeout_flag(timeout_flag)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {valid,bit,start,tmo} actual=%b expected=%b at %0t",
                     tag, act, exp, $time);
        end
    endtask

    // One sampling step with line level lv; optional sub-step glitch first.
    task automatic step(input logic lv, input bit glitch);
        logic e_valid, e_bit, e_start, e_tmo;
        logic edge_seen;
        int   gap;
        string tag;
        if (glitch) begin
            @(negedge clk) line_in = ~m_lvl;
            @(negedge clk) line_in = m_lvl;
        end
        @(negedge clk) line_in = lv;
        repeat (3) @(negedge clk);
        // R10: no strobe away from a tick
        check("R10", {bit_valid, 1'b0, start_flag, timeout_flag}, 4'b0000);
        step_tick = 1'b1;
        @(negedge clk) step_tick = 1'b0;
        edge_seen = (lv != m_lvl);
        gap = m_cnt + 1;
        e_valid = 0; e_bit = 0; e_start = 0; e_tmo = 0;
        tag = "R8";
        if (gap == 15) begin
            e_tmo = 1; m_idle = 1; tag = edge_seen ? "R5" : "R4";
        end else if (edge_seen && gap <= 14) begin
            e_valid = 1; e_bit = (gap >= 8);
            e_start = m_idle && e_bit && !lv;
            m_idle = 0;
            tag = e_start ? "R7" : (e_bit ? "R3" : "R2");
        end
        m_cnt = edge_seen ? 0 : ((m_cnt < 15) ? m_cnt + 1 : 15);
        m_lvl = lv;
        check(tag, {bit_valid, e_valid ? bit_out : 1'b0, start_flag, timeout_flag},
              {e_valid, e_bit, e_start, e_tmo});
    endtask

    // Hold the level for k-1 steps, then toggle in step k.
    task automatic gap_steps(input int k, input bit glitch);
        for (int i = 1; i < k; i++) step(m_lvl, glitch);
        step(~m_lvl, 1'b0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: outputs low during reset
        check("R1", {bit_valid, bit_out, start_flag, timeout_flag}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {bit_valid, bit_out, start_flag, timeout_flag}, 4'b0000);

        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);          // R8: first toggle opens only
        gap_steps(11, 1'b0);       // R7: high pulse decodes start '1'
        gap_steps(4, 1'b0);        // R2, R6 rising
        gap_steps(1, 1'b0);        // R2 minimum
        gap_steps(7, 1'b0);        // R2 maximum
        gap_steps(8, 1'b0);        // R3 minimum
        gap_steps(14, 1'b0);       // R3 maximum
        for (int i = 0; i < 20; i++) step(m_lvl, 1'b0);  // R4 single timeout
        step(~m_lvl, 1'b0);        // R8 after timeout
        gap_steps(15, 1'b0);       // R5 toggle in timeout step
        gap_steps(4, 1'b0);        // R5 count restarted at that toggle
        gap_steps(6, 1'b1);        // R9 glitches ignored
        gap_steps(9, 1'b1);        // R9 glitches ignored on '1'
        for (int n = 0; n < 500; n++)
            gap_steps(int'($urandom_range(17, 1)), ($urandom_range(7, 0) == 0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule